// File: doc/BRIEF.md
# Pin Function Multiplexer

This block sits between a small controller's I/O pads and its on-chip logic. Each pin owns a function-select register that puts the pin in one of three kinds of mode: plain GPIO, analog, or one of six peripheral functions. Two of the peripheral functions are the I2C clock and the I2C data line. Out of the selected mode the block derives the pad's output value, output enable, pull-up enable and open-drain enable. It also gates the pad's digital input, which is shut off in analog mode.

A second set of registers chooses, for each of thirteen input-only internal functions, which pin feeds it. The functions are two external interrupts, timer clocks and gates, four capture channels and an ADC trigger. An allocation works whatever the pin's mode is, as long as the pin's digital input is live. Every register sits on a simple single-cycle register bus: a write lands on the rising edge, and the read data is combinational from the address.

Top module: `iomux_top`

## Requirements
- R1: A pin's function register is at 0xF000 plus the pin index, where the index is port*8 plus the bit. The register resets to 0x01. Only bits 2:0 are stored, and bits 7:3 always read as 0.
- R2: With function code 001 (analog), the pin's output enable, pull-up and open-drain outputs are all 0, and the pin's gated digital input reads 0 whatever the pad level is.
- R3: With function code 000 (GPIO), the pad output is the port's data bit and the output enable is the direction bit (1 = drive). Pull-up and open-drain follow the software bits, and the gated input follows the pad.
- R4: With codes 4 to 7, the pad output and enable come from peripheral line code-2. Code 4 is the buzzer. Pull-up and open-drain are forced to 0, and the direction, pull-up and open-drain bits have no effect.
- R5: With code 2 (I2C clock) or code 3 (I2C data), open-drain is forced to 1 and the pull-up follows the software bit. Output and enable come from peripheral lines 0 and 1.
- R6: The allocation registers are at 0xF0C0 to 0xF0CC. They drive infn_in bits 0 to 12 in this order: INT0, INT1, T0, T0G, T1, T1G, T2, T2EX, CAP0, CAP1, CAP2, CAP3, ADC trigger. Each resets to 0xFF and reads back all 8 bits.
- R7: An allocation value below the pin count routes that pin's gated input to the function. This holds in GPIO and in peripheral modes, and several functions may share one pin.
- R8: An allocation value at or above the pin count (16) selects no pin, and the function input then sits at its idle level 0.
- R9: For port p, the data latch is at 0xF080+p, direction at 0xF088+p, pull-up at 0xF090+p and open-drain at 0xF098+p. All reset to 0 and read back. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| fn_out | input | 6 | Peripheral output values, line k serves code k+2 |
| fn_oe | input | 6 | Peripheral output enables, line k serves code k+2 |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| pad_pu | output | 16 | Pad pull-up enables |
| pad_od | output | 16 | Pad open-drain enables |
| pin_din | output | 16 | Gated pin inputs |
| infn_in | output | 13 | Input-only function inputs |

## Verification
Output steering and input allocation can both act on one pin in the same cycle. In the test, pin 9 is in buzzer mode and drives the buzzer line while it is also allocated to INT1 and T0. The bench then changes pad_in[9] and fn_out[2] on the same falling edge and checks pad_out[9] and both function inputs together. A second case writes a pin's function register while that pin is allocated. This shows the routed input dropping to idle in the cycle after the pin is switched to analog.

// File: rtl/iomux_pkg.sv
// Package: shared encodings for the pin function multiplexer.
// Assumes 8 pins per port and 8-bit registers.
package iomux_pkg;
    localparam int PORT_PINS = 8;
    localparam int REG_W     = 8;
    localparam int FN_W      = 3;
    localparam int NUM_PFN   = 6;   // peripheral lines for codes 2..7

    typedef enum logic [FN_W-1:0] {
        FN_GPIO    = 3'd0,
        FN_ANALOG  = 3'd1,
        FN_I2C_CLK = 3'd2,
        FN_I2C_DAT = 3'd3,
        FN_BUZZER  = 3'd4,
        FN_ALT5    = 3'd5,
        FN_ALT6    = 3'd6,
        FN_ALT7    = 3'd7
    } pin_fn_e;

    localparam logic [REG_W-1:0] ALLOC_NONE = 8'hFF;
endpackage

// File: rtl/iomux_regbank.sv
// Register bank: function registers per pin, GPIO latches per port, and
// input allocation registers. Writes land on the rising edge; reads are
// combinational. Assumes all register addresses are distinct.
module iomux_regbank
    import iomux_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int NUM_INFN  = 13,
    parameter int ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CFG_BASE   = 16'hF000,
    parameter logic [ADDR_W-1:0] PORT_BASE  = 16'hF080,
    parameter logic [ADDR_W-1:0] ALLOC_BASE = 16'hF0C0,
    localparam int NUM_PINS = NUM_PORTS * PORT_PINS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [REG_W-1:0]          bus_wdata,
    output logic [REG_W-1:0]          bus_rdata,
    output pin_fn_e                   cfg_o [NUM_PINS],
    output logic [NUM_PINS-1:0]       dat_o,
    output logic [NUM_PINS-1:0]       dir_o,
    output logic [NUM_PINS-1:0]       pu_o,
    output logic [NUM_PINS-1:0]       od_o,
    output logic [REG_W-1:0]          alloc_o [NUM_INFN]
);
    localparam logic [ADDR_W-1:0] DIR_OFS = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] PU_OFS  = ADDR_W'(16);
    localparam logic [ADDR_W-1:0] OD_OFS  = ADDR_W'(24);

    pin_fn_e          cfg_q   [NUM_PINS];
    logic [REG_W-1:0] dat_q   [NUM_PORTS];
    logic [REG_W-1:0] dir_q   [NUM_PORTS];
    logic [REG_W-1:0] pu_q    [NUM_PORTS];
    logic [REG_W-1:0] od_q    [NUM_PORTS];
    logic [REG_W-1:0] alloc_q [NUM_INFN];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_cfg
        localparam logic [ADDR_W-1:0] A = CFG_BASE + ADDR_W'(p);
        // Function register of one pin; only the low three bits are kept.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[p] <= FN_ANALOG;
            else if (bus_we && bus_addr == A)
                cfg_q[p] <= pin_fn_e'(bus_wdata[FN_W-1:0]);
        end
        assign cfg_o[p] = cfg_q[p];
    end

    for (genvar q = 0; q < NUM_PORTS; q++) begin : g_port
        localparam logic [ADDR_W-1:0] A = PORT_BASE + ADDR_W'(q);
        // GPIO latches of one port: data, direction, pull-up, open-drain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dat_q[q] <= '0;
                dir_q[q] <= '0;
                pu_q[q]  <= '0;
                od_q[q]  <= '0;
            end else if (bus_we) begin
                if (bus_addr == A)           dat_q[q] <= bus_wdata;
                if (bus_addr == A + DIR_OFS) dir_q[q] <= bus_wdata;
                if (bus_addr == A + PU_OFS)  pu_q[q]  <= bus_wdata;
                if (bus_addr == A + OD_OFS)  od_q[q]  <= bus_wdata;
            end
        end
        assign dat_o[q*PORT_PINS +: PORT_PINS] = dat_q[q];
        assign dir_o[q*PORT_PINS +: PORT_PINS] = dir_q[q];
        assign pu_o[q*PORT_PINS +: PORT_PINS]  = pu_q[q];
        assign od_o[q*PORT_PINS +: PORT_PINS]  = od_q[q];
    end

    for (genvar k = 0; k < NUM_INFN; k++) begin : g_alloc
        localparam logic [ADDR_W-1:0] A = ALLOC_BASE + ADDR_W'(k);
        // Allocation register of one input-only function.
        always_ff @(posedge clk) begin
            if (!rst_n)
                alloc_q[k] <= ALLOC_NONE;
            else if (bus_we && bus_addr == A)
                alloc_q[k] <= bus_wdata;
        end
        assign alloc_o[k] = alloc_q[k];
    end

    // Read mux: one match at most, unmapped addresses give zero.
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PINS; p++)
            if (bus_addr == CFG_BASE + ADDR_W'(p))
                bus_rdata = {{(REG_W-FN_W){1'b0}}, cfg_q[p]};
        for (int q = 0; q < NUM_PORTS; q++) begin
            if (bus_addr == PORT_BASE + ADDR_W'(q))           bus_rdata = dat_q[q];
            if (bus_addr == PORT_BASE + ADDR_W'(q) + DIR_OFS) bus_rdata = dir_q[q];
            if (bus_addr == PORT_BASE + ADDR_W'(q) + PU_OFS)  bus_rdata = pu_q[q];
            if (bus_addr == PORT_BASE + ADDR_W'(q) + OD_OFS)  bus_rdata = od_q[q];
        end
        for (int k = 0; k < NUM_INFN; k++)
            if (bus_addr == ALLOC_BASE + ADDR_W'(k))
                bus_rdata = alloc_q[k];
    end
endmodule

// File: rtl/iomux_pad_ctl.sv
// Pad control for one pin: turns the function code and the GPIO bits into
// the pad drive and input gating. Purely combinational.
module iomux_pad_ctl
    import iomux_pkg::*;
(
    input  pin_fn_e              fn,
    input  logic                 dat,
    input  logic                 dir,
    input  logic                 pu,
    input  logic                 od,
    input  logic [NUM_PFN-1:0]   fn_out,
    input  logic [NUM_PFN-1:0]   fn_oe,
    input  logic                 pad_in,
    output logic                 pad_out,
    output logic                 pad_oe,
    output logic                 pad_pu,
    output logic                 pad_od,
    output logic                 din
);
    logic [FN_W-1:0] line;
    assign line = FN_W'(fn) - FN_W'(2);

    // Mode decode: GPIO uses software bits, analog is quiet, peripherals override.
    always_comb begin
        pad_out = 1'b0;
        pad_oe  = 1'b0;
        pad_pu  = 1'b0;
        pad_od  = 1'b0;
        din     = pad_in;
        unique case (fn)
            FN_GPIO: begin
                pad_out = dat;
                pad_oe  = dir;
                pad_pu  = pu;
                pad_od  = od;
            end
            FN_ANALOG: din = 1'b0;
            FN_I2C_CLK, FN_I2C_DAT: begin
                pad_out = fn_out[line];
                pad_oe  = fn_oe[line];
                pad_pu  = pu;
                pad_od  = 1'b1;
            end
            default: begin
                pad_out = fn_out[line];
                pad_oe  = fn_oe[line];
            end
        endcase
    end
endmodule

// File: rtl/iomux_in_route.sv
// Input router for one input-only function: picks the gated input of the
// allocated pin, or the idle level when the allocation names no pin.
module iomux_in_route
    import iomux_pkg::*;
#(
    parameter int NUM_PINS = 16,
    localparam int IDX_W = $clog2(NUM_PINS)
) (
    input  logic [REG_W-1:0]    sel,
    input  logic [NUM_PINS-1:0] pin_din,
    input  logic                idle,
    output logic                fn_in
);
    // Range check, then pin select.
    always_comb begin
        if (int'(sel) < NUM_PINS)
            fn_in = pin_din[sel[IDX_W-1:0]];
        else
            fn_in = idle;
    end
endmodule

// File: rtl/iomux_top.sv
// Top of the pin function multiplexer: register bank, one pad controller per
// pin and one router per input-only function. Assumes 8-pin ports.
module iomux_top
    import iomux_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int NUM_INFN  = 13,
    parameter int ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CFG_BASE   = 16'hF000,
    parameter logic [ADDR_W-1:0] PORT_BASE  = 16'hF080,
    parameter logic [ADDR_W-1:0] ALLOC_BASE = 16'hF0C0,
    parameter logic [NUM_INFN-1:0] INFN_IDLE = '0,
    localparam int NUM_PINS = NUM_PORTS * PORT_PINS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    input  logic [5:0]           fn_out,
    input  logic [5:0]           fn_oe,
    input  logic [NUM_PINS-1:0]  pad_in,
    output logic [NUM_PINS-1:0]  pad_out,
    output logic [NUM_PINS-1:0]  pad_oe,
    output logic [NUM_PINS-1:0]  pad_pu,
    output logic [NUM_PINS-1:0]  pad_od,
    output logic [NUM_PINS-1:0]  pin_din,
    output logic [NUM_INFN-1:0]  infn_in
);
    pin_fn_e              cfg   [NUM_PINS];
    logic [REG_W-1:0]     alloc [NUM_INFN];
    logic [NUM_PINS-1:0]  dat, dir, pu, od;
    logic [FN_W*NUM_PINS-1:0]  cfg_flat;
    logic [REG_W*NUM_INFN-1:0] alloc_flat;

    iomux_regbank #(
        .NUM_PORTS(NUM_PORTS), .NUM_INFN(NUM_INFN), .ADDR_W(ADDR_W),
        .CFG_BASE(CFG_BASE), .PORT_BASE(PORT_BASE), .ALLOC_BASE(ALLOC_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_o(cfg),
        .dat_o(dat), .dir_o(dir), .pu_o(pu), .od_o(od), .alloc_o(alloc)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
        iomux_pad_ctl u_pad (
            .fn(cfg[p]), .dat(dat[p]), .dir(dir[p]), .pu(pu[p]), .od(od[p]),
            .fn_out(fn_out), .fn_oe(fn_oe), .pad_in(pad_in[p]),
            .pad_out(pad_out[p]), .pad_oe(pad_oe[p]), .pad_pu(pad_pu[p]),
            .pad_od(pad_od[p]), .din(pin_din[p])
        );
        assign cfg_flat[p*FN_W +: FN_W] = cfg[p];
    end

    for (genvar k = 0; k < NUM_INFN; k++) begin : g_route
        iomux_in_route #(.NUM_PINS(NUM_PINS)) u_route (
            .sel(alloc[k]), .pin_din(pin_din), .idle(INFN_IDLE[k]),
            .fn_in(infn_in[k])
        );
        assign alloc_flat[k*REG_W +: REG_W] = alloc[k];
    end
endmodule

// File: rtl/iomux_top_chk.sv
// Checker for iomux_top: mode rules per pin, idle routing, reserved bits.
module iomux_top_chk #(
    parameter int NUM_PINS = 16,
    parameter int NUM_INFN = 13,
    parameter int ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CFG_BASE = 16'hF000,
    parameter logic [NUM_INFN-1:0] INFN_IDLE = '0
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [7:0]             bus_rdata,
    input logic [NUM_PINS-1:0]    pad_in,
    input logic [NUM_PINS-1:0]    pad_oe,
    input logic [NUM_PINS-1:0]    pad_pu,
    input logic [NUM_PINS-1:0]    pad_od,
    input logic [NUM_PINS-1:0]    pin_din,
    input logic [NUM_INFN-1:0]    infn_in,
    input logic [3*NUM_PINS-1:0]  cfg_flat,
    input logic [8*NUM_INFN-1:0]  alloc_flat
);
    assert_cfg_resv_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= CFG_BASE && bus_addr < CFG_BASE + ADDR_W'(NUM_PINS))
        |-> bus_rdata[7:3] == 5'b0) else $error("reserved bits set");

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assert_analog_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_flat[p*3 +: 3] == 3'd1 |-> !(pad_oe[p] | pad_pu[p] | pad_od[p] | pin_din[p]))
            else $error("analog pin %0d active", p);
        assert_gpio_din_R3: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_flat[p*3 +: 3] == 3'd0 |-> pin_din[p] == pad_in[p])
            else $error("gpio pin %0d input blocked", p);
        assert_periph_nopull_R4: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_flat[p*3 +: 3] >= 3'd4 |-> !pad_pu[p] && !pad_od[p])
            else $error("peripheral pin %0d pull or od", p);
        assert_i2c_od_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_flat[p*3 +: 3] == 3'd2 || cfg_flat[p*3 +: 3] == 3'd3) |-> pad_od[p])
            else $error("i2c pin %0d not open-drain", p);
    end

    for (genvar k = 0; k < NUM_INFN; k++) begin : g_fn
        assert_none_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
            int'(alloc_flat[k*8 +: 8]) >= NUM_PINS |-> infn_in[k] == INFN_IDLE[k])
            else $error("unallocated function %0d not idle", k);
    end
endmodule

bind iomux_top iomux_top_chk #(
    .NUM_PINS(NUM_PINS), .NUM_INFN(NUM_INFN), .ADDR_W(ADDR_W),
    .CFG_BASE(CFG_BASE), .INFN_IDLE(INFN_IDLE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_od(pad_od),
    .pin_din(pin_din), .infn_in(infn_in), .cfg_flat(cfg_flat),
    .alloc_flat(alloc_flat)
);

// File: tb/iomux_top_test.sv
// Directed bench for iomux_top: one task per scenario, each checking itself.
module iomux_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [5:0]  fn_out = '0;
    logic [5:0]  fn_oe = '0;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe, pad_pu, pad_od, pin_din;
    logic [12:0] infn_in;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    iomux_top uut (.*);

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int p = 0; p < 16; p++) begin
            rd(16'hF000 + 16'(p), d);
            chk("R1 cfg reset", d, 8'h01);
        end
        for (int k = 0; k < 13; k++) begin
            rd(16'hF0C0 + 16'(k), d);
            chk("R6 alloc reset", d, 8'hFF);
        end
        pad_in = 16'hFFFF; #1;
        chk("R2 reset oe/pu/od", {pad_oe, pad_pu, pad_od}, 48'h0);
        chk("R2 reset din", pin_din, 16'h0);
        chk("R8 reset infn idle", infn_in, 13'h0);
        pad_in = '0;
    endtask

    task automatic t_cfg_resv();
        logic [7:0] d;
        wr(16'hF003, 8'hFF);
        rd(16'hF003, d);
        chk("R1 reserved bits read 0", d, 8'h07);
        wr(16'hF003, 8'hF8);
        rd(16'hF003, d);
        chk("R1 code 000 stored", d, 8'h00);
    endtask

    task automatic t_gpio();
        wr(16'hF080, 8'h08);   // data bit 3 = 1
        wr(16'hF088, 8'h08);   // dir bit 3 = out
        wr(16'hF090, 8'h08);
        wr(16'hF098, 8'h08);
        chk("R3 gpio out/oe/pu/od", {pad_out[3], pad_oe[3], pad_pu[3], pad_od[3]}, 4'hF);
        wr(16'hF088, 8'h00);
        wr(16'hF098, 8'h00);
        chk("R3 gpio dir=0 od=0", {pad_oe[3], pad_od[3], pad_pu[3]}, 3'b001);
        pad_in[3] = 1'b1; #1;
        chk("R3 gpio din", pin_din[3], 1'b1);
        pad_in[3] = 1'b0; #1;
        chk("R3 gpio din low", pin_din[3], 1'b0);
    endtask

    task automatic t_analog();
        wr(16'hF080, 8'hFF); wr(16'hF088, 8'hFF);
        wr(16'hF090, 8'hFF); wr(16'hF098, 8'hFF);
        wr(16'hF0C0, 8'd5);    // INT0 <- pin 5, pin 5 still analog
        pad_in[5] = 1'b1; #1;
        chk("R2 analog quiet", {pad_oe[5], pad_pu[5], pad_od[5]}, 3'b000);
        chk("R2 analog din 0", pin_din[5], 1'b0);
        chk("R2 analog routed 0", infn_in[0], 1'b0);
        wr(16'hF005, 8'h00);
        chk("R7 gpio pin routed", infn_in[0], 1'b1);
        wr(16'hF005, 8'h01);   // back to analog while allocated
        chk("R2 routed drops", infn_in[0], 1'b0);
        pad_in[5] = 1'b0;
    endtask

    task automatic t_periph();
        wr(16'hF081, 8'h00); wr(16'hF089, 8'h00);
        wr(16'hF091, 8'hFF); wr(16'hF099, 8'hFF);
        wr(16'hF009, 8'h04);   // pin 9 buzzer
        fn_out = 6'b000100; fn_oe = 6'b000100; #1;
        chk("R4 buzzer drive", {pad_out[9], pad_oe[9], pad_pu[9], pad_od[9]}, 4'b1100);
        wr(16'hF089, 8'hFF);
        fn_oe = 6'b0; #1;
        chk("R4 dir ignored", pad_oe[9], 1'b0);
        wr(16'hF009, 8'h07);
        fn_out = 6'b100000; fn_oe = 6'b100000; #1;
        chk("R4 code 7 line 5", {pad_out[9], pad_oe[9], pad_pu[9], pad_od[9]}, 4'b1100);
        wr(16'hF009, 8'h04);
        fn_out = 6'b0; fn_oe = 6'b0;
    endtask

    task automatic t_i2c();
        wr(16'hF00A, 8'h02);   // pin 10 I2C clock
        wr(16'hF09A, 8'h00);   // sw od off on port 1... pin 10 is bit 2
        wr(16'hF099, 8'h00);
        wr(16'hF091, 8'h04);
        fn_out = 6'b000001; fn_oe = 6'b000001; #1;
        chk("R5 i2c clk od/pu", {pad_out[10], pad_oe[10], pad_pu[10], pad_od[10]}, 4'b1111);
        wr(16'hF091, 8'h00);
        chk("R5 i2c pu follows sw", {pad_pu[10], pad_od[10]}, 2'b01);
        wr(16'hF00A, 8'h03);
        fn_out = 6'b000010; fn_oe = 6'b000000; #1;
        chk("R5 i2c data line 1", {pad_out[10], pad_oe[10], pad_od[10]}, 3'b101);
        fn_out = 6'b0;
    endtask

    task automatic t_alloc_order();
        logic [7:0] d;
        for (int k = 0; k < 13; k++) wr(16'hF0C0 + 16'(k), 8'(k));
        for (int k = 0; k < 13; k++) begin
            rd(16'hF0C0 + 16'(k), d);
            chk("R6 alloc readback", d, 8'(k));
        end
        for (int p = 0; p < 13; p++) wr(16'hF000 + 16'(p), 8'h00);
        for (int k = 0; k < 13; k++) begin
            pad_in = 16'(1) << k; #1;
            chk("R6 order one-hot", infn_in, 13'(1) << k);
        end
        pad_in = '0;
    endtask

    task automatic t_overlap();
        wr(16'hF009, 8'h04);      // pin 9 buzzer
        wr(16'hF0C1, 8'd9);       // INT1 <- pin 9
        wr(16'hF0C2, 8'd9);       // T0   <- pin 9
        fn_oe = 6'b000100;
        @(negedge clk);
        pad_in[9] = 1'b1; fn_out[2] = 1'b1; #1;
        chk("R7 shared pin INT1/T0", {infn_in[2], infn_in[1]}, 2'b11);
        chk("R4 buzzer same cycle", pad_out[9], 1'b1);
        @(negedge clk);
        pad_in[9] = 1'b0; fn_out[2] = 1'b0; #1;
        chk("R7 shared pin low", {infn_in[2], infn_in[1], pad_out[9]}, 3'b000);
        pad_in[9] = 1'b1; fn_oe = '0;
    endtask

    task automatic t_none();
        pad_in = 16'hFFFF;
        wr(16'hF0CC, 8'd16);
        #1 chk("R8 index 16 idle", infn_in[12], 1'b0);
        wr(16'hF0CC, 8'hFF);
        #1 chk("R8 0xFF idle", infn_in[12], 1'b0);
        wr(16'hF0CC, 8'd15);
        wr(16'hF00F, 8'h00);
        #1 chk("R7 pin 15 routes", infn_in[12], 1'b1);
        pad_in = '0;
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(16'hF080, 8'hA5); rd(16'hF080, d); chk("R9 data readback", d, 8'hA5);
        wr(16'hF089, 8'h3C); rd(16'hF089, d); chk("R9 dir readback", d, 8'h3C);
        wr(16'hF090, 8'h5A); rd(16'hF090, d); chk("R9 pu readback", d, 8'h5A);
        wr(16'hF099, 8'hC3); rd(16'hF099, d); chk("R9 od readback", d, 8'hC3);
        wr(16'hF0CD, 8'h77); rd(16'hF0CD, d); chk("R9 unmapped 0", d, 8'h00);
        rd(16'hF082, d); chk("R9 unmapped port 0", d, 8'h00);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cfg_resv();
        t_gpio();
        t_analog();
        t_periph();
        t_i2c();
        t_alloc_order();
        t_overlap();
        t_none();
        t_regs();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule